// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Sequencer

This block produces the write waveforms for one chip select of an asynchronous static memory. A client offers a word address, a 16-bit data word and two byte enables over a valid/ready request interface. The block captures the request together with a set of timing values. It then runs one bus write, counted in controller clocks. The write strobe and the chip-select strobe each have their own setup, pulse and total-cycle counts. The hold time of each strobe is whatever remains after its setup and pulse.

All strobes are active low. A mode input picks which strobe governs the data driver. With the write strobe in charge, the data output enable rises once the write-strobe setup has elapsed. With the chip select in charge, it rises once the chip-select setup has elapsed. In both modes it stays on until the cycle ends.

A one-clock done pulse marks the final clock of a write. A request taken in that same clock starts the next write with no idle clock between them. Because of this, a strobe programmed with zero setup and zero hold stays asserted across a burst of writes. A request whose timing is illegal is refused with an error pulse and starts no cycle. Timing is illegal when either pulse is zero, or when setup plus pulse exceeds the cycle count for either strobe.

Top module: `memWriteSeq`

## Requirements
- R1: After reset and whenever no write is running, memWeN and memCsN are 1, memBeN is all ones, memDataOe is 0, done is 0 and reqReady is 1.
- R2: When a request is accepted at a clock edge, the clock after that edge is cycle position 0. memWeN is 0 exactly at positions p with weSetup <= p < weSetup + wePulse.
- R3: memCsN is 0 exactly at positions p with csSetup <= p < csSetup + csPulse.
- R4: A write lasts L = max(weCycle, csCycle) clocks. done is 1 only at position L-1. While a write runs, reqReady is 1 only at position L-1.
- R5: With cfgWeCtrl = 1, memDataOe is 1 from position weSetup through position L-1.
- R6: With cfgWeCtrl = 0, memDataOe is 1 from position csSetup through position L-1.
- R7: Address, data, byte enables and all timing values are captured at acceptance. memAddr and memData show the captured values for the whole write. Changes to the request or timing inputs during a write have no effect on it.
- R8: A request is refused if any pulse count is 0, or if setup + pulse > cycle for either strobe. While such a request is valid and reqReady is 1, reqErr is 1, and no write starts.
- R9: A request accepted at position L-1 starts its position 0 in the very next clock. A strobe with zero setup and zero hold (pulse = cycle = L) then stays 0 across both writes.
- R10: During a write, memBeN = ~reqBe as captured. Bit 0 selects the low data byte and bit 1 the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request offered |
| reqReady | output | 1 | Request can be taken this clock |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables, active high |
| cfgWeSetup | input | CNT_W | Write strobe setup clocks |
| cfgWePulse | input | CNT_W | Write strobe pulse clocks |
| cfgWeCycle | input | CNT_W | Write strobe total cycle clocks |
| cfgCsSetup | input | CNT_W | Chip-select setup clocks |
| cfgCsPulse | input | CNT_W | Chip-select pulse clocks |
| cfgCsCycle | input | CNT_W | Chip-select total cycle clocks |
| cfgWeCtrl | input | 1 | 1: write strobe governs data enable; 0: chip select does |
| reqErr | output | 1 | Offered request has illegal timing |
| done | output | 1 | Final clock of the current write |
| memAddr | output | ADDR_W | Address to memory |
| memData | output | DATA_W | Data to memory |
| memDataOe | output | 1 | Data driver enable |
| memBeN | output | DATA_W/8 | Byte selects, active low |
| memWeN | output | 1 | Write strobe, active low |
| memCsN | output | 1 | Chip select, active low |

## Verification
The bench checks strobe windows for zero setup, a one-clock cycle and holds longer than the other strobe's cycle. An off-by-one in the window compare would move or stretch a strobe by a clock. It runs a back-to-back pair with zero setup and hold, where an idle clock between writes would show up as a strobe blip or a late restart. Timing inputs are scrambled during every write, so a design that reads them live instead of capturing them would bend its waveform. Zero-pulse and overrun requests are offered to confirm they raise the error and leave the bus quiet, rather than starting a broken cycle.

// File: rtl/mws_pkg.sv
package mws_pkg;
  // Strobes sent from the sequencer control to the datapath
  typedef struct packed {
    logic load;   // capture request fields at the next edge
    logic busy;   // a write is running
    logic weAct;  // write strobe asserted
    logic csAct;  // chip select asserted
    logic oeAct;  // data driver enabled
  } strb_t;
endpackage

// File: rtl/mws_window.sv
module mws_window #(
  parameter int CNT_W = 6
) (
  input  logic             active,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  output logic             on,
  output logic             pastSetup
);
  logic [CNT_W:0] winEnd;

  always_comb begin
    winEnd    = {1'b0, setup} + {1'b0, pulse};
    pastSetup = active && (pos >= setup);
    on        = pastSetup && ({1'b0, pos} < winEnd);
  end
endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             reqErr,
  output logic             done,
  input  logic [CNT_W-1:0] cfgWeSetup,
  input  logic [CNT_W-1:0] cfgWePulse,
  input  logic [CNT_W-1:0] cfgWeCycle,
  input  logic [CNT_W-1:0] cfgCsSetup,
  input  logic [CNT_W-1:0] cfgCsPulse,
  input  logic [CNT_W-1:0] cfgCsCycle,
  input  logic             cfgWeCtrl,
  output strb_t            strb
);
  localparam int NSTRB = 2;  // index 0: write strobe, 1: chip select
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] pos, lenM1, maxCyc;
  logic [CNT_W-1:0] setupQ [NSTRB];
  logic [CNT_W-1:0] pulseQ [NSTRB];
  logic [CNT_W-1:0] setupIn [NSTRB];
  logic [CNT_W-1:0] pulseIn [NSTRB];
  logic [CNT_W-1:0] cycleIn [NSTRB];
  logic [NSTRB-1:0] legal, winOn, winPast;
  logic             active, weModeQ, lastCyc, cfgOk, accept;

  always_comb begin
    setupIn[0] = cfgWeSetup; pulseIn[0] = cfgWePulse; cycleIn[0] = cfgWeCycle;
    setupIn[1] = cfgCsSetup; pulseIn[1] = cfgCsPulse; cycleIn[1] = cfgCsCycle;
  end

  // Per-strobe legality check and waveform window
  for (genvar g = 0; g < NSTRB; g++) begin : g_strobe
    logic [CNT_W:0] reach;
    always_comb begin
      reach    = {1'b0, setupIn[g]} + {1'b0, pulseIn[g]};
      legal[g] = (pulseIn[g] != '0) && (reach <= {1'b0, cycleIn[g]});
    end

    mws_window #(.CNT_W(CNT_W)) i_win (
      .active   (active),
      .pos      (pos),
      .setup    (setupQ[g]),
      .pulse    (pulseQ[g]),
      .on       (winOn[g]),
      .pastSetup(winPast[g])
    );
  end

  always_comb begin
    cfgOk    = &legal;
    maxCyc   = (cfgWeCycle > cfgCsCycle) ? cfgWeCycle : cfgCsCycle;
    lastCyc  = active && (pos == lenM1);
    reqReady = !active || lastCyc;
    accept   = reqValid && reqReady && cfgOk;
    reqErr   = reqValid && reqReady && !cfgOk;
    done     = lastCyc;

    strb.load  = accept;
    strb.busy  = active;
    strb.weAct = winOn[0];
    strb.csAct = winOn[1];
    strb.oeAct = weModeQ ? winPast[0] : winPast[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      pos     <= '0;
      lenM1   <= '0;
      weModeQ <= 1'b0;
      for (int i = 0; i < NSTRB; i++) begin
        setupQ[i] <= '0;
        pulseQ[i] <= '0;
      end
    end else if (accept) begin
      active  <= 1'b1;
      pos     <= '0;
      lenM1   <= maxCyc - ONE;
      weModeQ <= cfgWeCtrl;
      for (int i = 0; i < NSTRB; i++) begin
        setupQ[i] <= setupIn[i];
        pulseQ[i] <= pulseIn[i];
      end
    end else if (lastCyc) begin
      active <= 1'b0;
    end else if (active) begin
      pos <= pos + ONE;
    end
  end

  // Position never runs past the captured cycle length
  p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (pos <= lenM1));

  // A refused request from idle leaves the bus idle
  p_err_no_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqErr && !active) |=> !active);

  // Captured pulses are always non-zero while running
  p_pulse_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (pulseQ[0] != '0) && (pulseQ[1] != '0));

  // Request taken in the final clock restarts at position 0
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lastCyc && reqValid && cfgOk) |=> (active && pos == '0));

  // Once on, the data enable holds until the final clock
  p_oe_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.oeAct && !lastCyc) |=> strb.oeAct);
endmodule

// File: rtl/mws_datapath.sv
module mws_datapath
  import mws_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memDataOe,
  output logic [BE_W-1:0]   memBeN,
  output logic              memWeN,
  output logic              memCsN
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BE_W-1:0]   beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      beQ   <= reqBe;
    end
  end

  always_comb begin
    memAddr   = addrQ;
    memData   = dataQ;
    memDataOe = strb.oeAct;
    memBeN    = strb.busy ? ~beQ : '1;
    memWeN    = ~strb.weAct;
    memCsN    = ~strb.csAct;
  end

  // Bus fields only move when a new write is captured
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(memData) && $stable(memAddr)));
endmodule

// File: rtl/memWriteSeq.sv
module memWriteSeq
  import mws_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [CNT_W-1:0]  cfgWeSetup,
  input  logic [CNT_W-1:0]  cfgWePulse,
  input  logic [CNT_W-1:0]  cfgWeCycle,
  input  logic [CNT_W-1:0]  cfgCsSetup,
  input  logic [CNT_W-1:0]  cfgCsPulse,
  input  logic [CNT_W-1:0]  cfgCsCycle,
  input  logic              cfgWeCtrl,
  output logic              reqErr,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memDataOe,
  output logic [BE_W-1:0]   memBeN,
  output logic              memWeN,
  output logic              memCsN
);
  strb_t strb;

  mws_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqErr    (reqErr),
    .done      (done),
    .cfgWeSetup(cfgWeSetup),
    .cfgWePulse(cfgWePulse),
    .cfgWeCycle(cfgWeCycle),
    .cfgCsSetup(cfgCsSetup),
    .cfgCsPulse(cfgCsPulse),
    .cfgCsCycle(cfgCsCycle),
    .cfgWeCtrl (cfgWeCtrl),
    .strb      (strb)
  );

  mws_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqBe    (reqBe),
    .memAddr  (memAddr),
    .memData  (memData),
    .memDataOe(memDataOe),
    .memBeN   (memBeN),
    .memWeN   (memWeN),
    .memCsN   (memCsN)
  );

  // Outside a write the bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && !done |-> (memWeN && memCsN && !memDataOe && (memBeN == '1)));
endmodule

// File: tb/test_memWriteSeq.sv
module test_memWriteSeq;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam int NV = 8;
  // Vector fields: weSetup, wePulse, weCycle, csSetup, csPulse, csCycle, mode
  localparam int VWS[NV] = '{1, 2, 0, 3, 0, 5, 1, 4};
  localparam int VWP[NV] = '{2, 1, 1, 4, 2, 1, 1, 3};
  localparam int VWC[NV] = '{4, 3, 1, 8, 2, 7, 2, 10};
  localparam int VCS[NV] = '{0, 1, 0, 1, 2, 0, 1, 2};
  localparam int VCP[NV] = '{4, 3, 1, 6, 2, 7, 1, 5};
  localparam int VCC[NV] = '{4, 5, 1, 8, 6, 7, 3, 9};
  localparam int VMD[NV] = '{1, 0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic [1:0] reqBe = '0;
  logic [CW-1:0] cfgWeSetup = '0, cfgWePulse = '0, cfgWeCycle = '0;
  logic [CW-1:0] cfgCsSetup = '0, cfgCsPulse = '0, cfgCsCycle = '0;
  logic cfgWeCtrl = 1'b0;
  logic reqReady, reqErr, done, memDataOe, memWeN, memCsN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic [1:0] memBeN;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  memWriteSeq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_memWriteSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .cfgWeSetup(cfgWeSetup), .cfgWePulse(cfgWePulse), .cfgWeCycle(cfgWeCycle),
    .cfgCsSetup(cfgCsSetup), .cfgCsPulse(cfgCsPulse), .cfgCsCycle(cfgCsCycle),
    .cfgWeCtrl(cfgWeCtrl), .reqErr(reqErr), .done(done), .memAddr(memAddr),
    .memData(memData), .memDataOe(memDataOe), .memBeN(memBeN),
    .memWeN(memWeN), .memCsN(memCsN));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic setCfg(input int ws, wp, wc, cs, cp, cc, md);
    cfgWeSetup = CW'(ws); cfgWePulse = CW'(wp); cfgWeCycle = CW'(wc);
    cfgCsSetup = CW'(cs); cfgCsPulse = CW'(cp); cfgCsCycle = CW'(cc);
    cfgWeCtrl  = md[0];
  endtask

  task automatic chkIdle(input string tag);
    chk(memWeN === 1'b1, tag, "idle memWeN", int'(memWeN), 1);
    chk(memCsN === 1'b1, tag, "idle memCsN", int'(memCsN), 1);
    chk(memDataOe === 1'b0, tag, "idle memDataOe", int'(memDataOe), 0);
    chk(done === 1'b0, tag, "idle done", int'(done), 0);
    chk(memBeN === 2'b11, tag, "idle memBeN", int'(memBeN), 3);
    chk(reqReady === 1'b1, tag, "idle reqReady", int'(reqReady), 1);
  endtask

  task automatic runVec(input int i);
    int len, oeFrom;
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    logic [1:0] be;
    len    = (VWC[i] > VCC[i]) ? VWC[i] : VCC[i];
    oeFrom = VMD[i] ? VWS[i] : VCS[i];
    d  = DW'(16'hA55A ^ (i * 16'h1357));
    a  = AW'(22'h2A0F0 + i * 37);
    be = 2'(i + 1);
    @(posedge clk); #1;
    setCfg(VWS[i], VWP[i], VWC[i], VCS[i], VCP[i], VCC[i], VMD[i]);
    reqAddr = a; reqData = d; reqBe = be; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    // R7: scramble inputs during the write; the waveform must not change
    setCfg(0, 0, 1, 9, 0, 2, VMD[i] ^ 1);
    reqData = ~d; reqAddr = ~a; reqBe = ~be;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(memWeN === !(k >= VWS[i] && k < VWS[i] + VWP[i]), "R2", "memWeN",
          int'(memWeN), int'(!(k >= VWS[i] && k < VWS[i] + VWP[i])));
      chk(memCsN === !(k >= VCS[i] && k < VCS[i] + VCP[i]), "R3", "memCsN",
          int'(memCsN), int'(!(k >= VCS[i] && k < VCS[i] + VCP[i])));
      chk(done === (k == len - 1), "R4", "done", int'(done), int'(k == len - 1));
      chk(reqReady === (k == len - 1), "R4", "reqReady", int'(reqReady),
          int'(k == len - 1));
      chk(memDataOe === (k >= oeFrom), VMD[i] ? "R5" : "R6", "memDataOe",
          int'(memDataOe), int'(k >= oeFrom));
      chk(memData === d && memAddr === a, "R7", "memData", int'(memData), int'(d));
      chk(memBeN === ~be, "R10", "memBeN", int'(memBeN), int'(~be));
    end
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    for (int i = 0; i < NV; i++) runVec(i);
    @(negedge clk);
    chkIdle("R1");

    // R8: zero write pulse is refused
    @(posedge clk); #1;
    setCfg(1, 0, 3, 0, 3, 3, 1);
    reqValid = 1'b1;
    @(negedge clk);
    chk(reqErr === 1'b1, "R8", "reqErr zero pulse", int'(reqErr), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    chkIdle("R8");
    chk(reqErr === 1'b0, "R8", "reqErr after drop", int'(reqErr), 0);

    // R8: chip-select setup + pulse overruns its cycle
    @(posedge clk); #1;
    setCfg(0, 2, 4, 3, 3, 5, 0);
    reqValid = 1'b1;
    @(negedge clk);
    chk(reqErr === 1'b1, "R8", "reqErr overrun", int'(reqErr), 1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    chkIdle("R8");

    // R9: back-to-back writes with zero setup and hold on both strobes
    @(posedge clk); #1;
    setCfg(0, 3, 3, 0, 3, 3, 1);
    reqAddr = 22'h111; reqData = 16'h1234; reqBe = 2'b11; reqValid = 1'b1;
    @(posedge clk); #1;
    reqAddr = 22'h222; reqData = 16'hBEEF; reqBe = 2'b10;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(memWeN === 1'b0, "R9", "memWeN burst", int'(memWeN), 0);
      chk(memCsN === 1'b0, "R9", "memCsN burst", int'(memCsN), 0);
      chk(memData === (k < 3 ? 16'h1234 : 16'hBEEF), "R9", "memData burst",
          int'(memData), k < 3 ? 32'h1234 : 32'hBEEF);
      chk(done === (k == 2 || k == 5), "R9", "done burst", int'(done),
          int'(k == 2 || k == 5));
      chk(memBeN === (k < 3 ? 2'b00 : 2'b01), "R10", "memBeN burst",
          int'(memBeN), k < 3 ? 0 : 1);
      if (k == 3) begin
        @(posedge clk); #1;
        reqValid = 1'b0;
      end
    end
    @(negedge clk);
    chkIdle("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule